// File: doc/BRIEF.md
# I2C Bus Line Recovery Sequencer

This block brings an I2C port back to a usable state when the controller's input filters or its bus-busy detection have locked up. On a start strobe it turns the controller off, takes the SCL and SDA pads into general-purpose open-drain mode, and moves both wires through a fixed pattern of low and high levels. After each change it reads the line back. Forcing a real transition on each wire brings the controller's filtered view of the bus back in line with the pad, so its stuck busy state can clear. The block then gives the pads back to the controller, pulses its soft reset and turns it on again.

Every step first holds its drive for a programmable number of cycles, so each pulse meets the bus low and high times. It then waits, for at most a programmable number of cycles, for the line to show the level it expects. If that level never appears, the block releases both wires, returns the pads, leaves the controller disabled and raises its error output. The error stays high until a new start strobe.

States: `ST_IDLE`, `ST_DISABLE`, `ST_REL_BOTH`, `ST_SDA_LOW`, `ST_SCL_LOW`, `ST_SCL_HIGH`, `ST_SDA_HIGH`, `ST_HANDBACK`, `ST_RST_SET`, `ST_RST_CLR`, `ST_ENABLE`, `ST_FAULT`.

Transitions:
- idle or fault to disable on start
- disable to release-both after one cycle
- each line step to the next when its hold has elapsed and its level is seen (sda-high goes to handback)
- any line step to fault when its wait limit is used up
- handback to rst-set, rst-set to rst-clr, rst-clr to enable, and enable to idle, one cycle each

Top module: `i2c_line_recovery`

## Requirements
- R1: After reset the controller enable is 1, the pads belong to the controller (`pad_gpio_sel_o`=0), neither line is pulled low, and done, error and soft reset are 0.
- R2: A start strobe seen in idle or fault first spends one cycle with the controller enable at 0 while the pads still belong to the controller. Only after that cycle are the pads switched to GPIO.
- R3: The line steps run in this order, each with its own drive and expected level: both released, expect both high; SDA pulled low, expect SDA low; SCL also pulled low, expect SCL low; SCL released with SDA still low, expect SCL high; SDA released, expect SDA high. SCL is first pulled low only after SDA has been read low.
- R4: Each line step keeps its drive for at least `cfg_hold_i` cycles before the level is checked. A step whose line answers at once lasts max(`cfg_hold_i`, 2)+1 cycles.
- R5: Line levels are compared only after a two-flop synchronizer, so a pad change reaches the comparison two clock edges after it happens.
- R6: When a step's expected level is not seen in `cfg_timeout_i`+1 consecutive checks, the block enters fault. In fault both lines are released, the pads go back to the controller, the enable stays 0 and `error_o` is 1 until the next start.
- R7: After the SDA-high step the pads are handed back for one cycle with the enable still 0. The soft reset is then 1 for exactly one cycle, then 0 for one cycle, and then the enable returns to 1.
- R8: `done_o` is a single-cycle pulse in the cycle the enable returns to 1, and it is never high at the same time as `error_o`.
- R9: A start strobe that arrives while a sequence is running has no effect on the outputs or on the sequence length.
- R10: Neither line is pulled low unless the pads are selected as GPIO.
- R11: The soft reset is never high while the controller enable is 1, and the enable rises only two cycles after a soft-reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled in idle or fault |
| cfg_hold_i | input | CNT_W | Minimum cycles each step holds its drive |
| cfg_timeout_i | input | CNT_W | Extra checks allowed after the first one before fault |
| scl_pad_i | input | 1 | Raw SCL pad level |
| sda_pad_i | input | 1 | Raw SDA pad level |
| pad_gpio_sel_o | output | 1 | 1: pads in GPIO open-drain mode, 0: controller function |
| scl_pull_low_o | output | 1 | Open-drain enable pulling SCL low |
| sda_pull_low_o | output | 1 | Open-drain enable pulling SDA low |
| ctrl_enable_o | output | 1 | Enable to the I2C controller |
| ctrl_soft_rst_o | output | 1 | Soft reset to the I2C controller |
| done_o | output | 1 | One-cycle pulse when recovery completes |
| error_o | output | 1 | High in fault after a level timeout |

## Verification
Some properties are checked on every cycle by the assertions. SCL is never pulled low before SDA has been read low. The soft reset and the enable never overlap, and the enable returns only two cycles after the soft-reset pulse. Done is a lone pulse, and a fault is entered only after the wait counter has reached its limit. Other behaviour can only be shown by the bench's scenarios, using a model that follows the pads and the synchronizer delay. These cover the exact length of each step under different hold settings, the two-edge synchronizer latency, the timeout length with a wire held low, recovery from fault, and a start strobe that is ignored in mid-sequence.

// File: rtl/lrec_pkg.sv
package lrec_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DISABLE,
        ST_REL_BOTH,
        ST_SDA_LOW,
        ST_SCL_LOW,
        ST_SCL_HIGH,
        ST_SDA_HIGH,
        ST_HANDBACK,
        ST_RST_SET,
        ST_RST_CLR,
        ST_ENABLE,
        ST_FAULT
    } lrec_state_e;

    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/lrec_sync.sv
module lrec_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Idle bus reads high, so the chain resets to ones.
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lrec_counter.sv
module lrec_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o != {W{1'b1}})) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_line_recovery.sv
module i2c_line_recovery
    import lrec_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cfg_hold_i,
    input  logic [CNT_W-1:0] cfg_timeout_i,
    input  logic             scl_pad_i,
    input  logic             sda_pad_i,
    output logic             pad_gpio_sel_o,
    output logic             scl_pull_low_o,
    output logic             sda_pull_low_o,
    output logic             ctrl_enable_o,
    output logic             ctrl_soft_rst_o,
    output logic             done_o,
    output logic             error_o
);
    lrec_state_e state_q, state_d;

    logic [NUM_LINES-1:0] line_sync;
    logic scl_s, sda_s;
    logic [CNT_W-1:0] hold_cnt, wait_cnt;
    logic cnt_clr, hold_inc, wait_inc;
    logic hold_met, wait_spent, level_ok, in_step;
    lrec_state_e step_next;

    lrec_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_pad_i, scl_pad_i}),
        .sync_o  (line_sync)
    );
    assign scl_s = line_sync[LINE_SCL];
    assign sda_s = line_sync[LINE_SDA];

    lrec_counter #(.W(CNT_W)) u_hold_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(hold_inc), .count_o(hold_cnt)
    );
    lrec_counter #(.W(CNT_W)) u_wait_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(wait_inc), .count_o(wait_cnt)
    );

    assign hold_met   = (hold_cnt >= cfg_hold_i);
    assign wait_spent = (wait_cnt >= cfg_timeout_i);

    // Expected level and successor of each line step.
    always_comb begin
        level_ok  = 1'b0;
        step_next = ST_FAULT;
        in_step   = 1'b1;
        unique case (state_q)
            ST_REL_BOTH: begin level_ok = scl_s & sda_s; step_next = ST_SDA_LOW;  end
            ST_SDA_LOW:  begin level_ok = ~sda_s;        step_next = ST_SCL_LOW;  end
            ST_SCL_LOW:  begin level_ok = ~scl_s;        step_next = ST_SCL_HIGH; end
            ST_SCL_HIGH: begin level_ok = scl_s;         step_next = ST_SDA_HIGH; end
            ST_SDA_HIGH: begin level_ok = sda_s;         step_next = ST_HANDBACK; end
            default:     in_step = 1'b0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        hold_inc = 1'b0;
        wait_inc = 1'b0;
        if (in_step) begin
            if (!hold_met) begin
                hold_inc = 1'b1;
            end else if (level_ok) begin
                state_d = step_next;
                cnt_clr = 1'b1;
            end else if (wait_spent) begin
                state_d = ST_FAULT;
                cnt_clr = 1'b1;
            end else begin
                wait_inc = 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FAULT: begin
                    if (start_i) begin
                        state_d = ST_DISABLE;
                        cnt_clr = 1'b1;
                    end
                end
                ST_DISABLE:  begin state_d = ST_REL_BOTH; cnt_clr = 1'b1; end
                ST_HANDBACK: state_d = ST_RST_SET;
                ST_RST_SET:  state_d = ST_RST_CLR;
                ST_RST_CLR:  state_d = ST_ENABLE;
                ST_ENABLE:   state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        pad_gpio_sel_o  = 1'b0;
        scl_pull_low_o  = 1'b0;
        sda_pull_low_o  = 1'b0;
        ctrl_enable_o   = 1'b0;
        ctrl_soft_rst_o = 1'b0;
        done_o          = 1'b0;
        error_o         = 1'b0;
        unique case (state_q)
            ST_IDLE:     ctrl_enable_o = 1'b1;
            ST_REL_BOTH: pad_gpio_sel_o = 1'b1;
            ST_SDA_LOW:  begin pad_gpio_sel_o = 1'b1; sda_pull_low_o = 1'b1; end
            ST_SCL_LOW:  begin pad_gpio_sel_o = 1'b1; sda_pull_low_o = 1'b1; scl_pull_low_o = 1'b1; end
            ST_SCL_HIGH: begin pad_gpio_sel_o = 1'b1; sda_pull_low_o = 1'b1; end
            ST_SDA_HIGH: pad_gpio_sel_o = 1'b1;
            ST_RST_SET:  ctrl_soft_rst_o = 1'b1;
            ST_ENABLE:   begin ctrl_enable_o = 1'b1; done_o = 1'b1; end
            ST_FAULT:    error_o = 1'b1;
            default:     ;
        endcase
    end

    // SCL is first pulled low only once SDA has been read low.
    assert_scl_after_sda_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low_o) |-> $past(!sda_s));

    // A fault follows only an exhausted wait window.
    assert_fault_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> ($past(wait_cnt) >= $past(cfg_timeout_i)));

    // Enable returns two cycles after the soft-reset pulse.
    assert_enable_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_soft_rst_o) |=> ctrl_enable_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_no_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !error_o);

    assert_enable_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_enable_o) |-> $past(ctrl_soft_rst_o, 2));

    // Pulled-low lines only while the pads are in GPIO mode.
    assert_drive_gpio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low_o) |-> $past(pad_gpio_sel_o));
endmodule

// File: tb/i2c_line_recovery_bench.sv
module i2c_line_recovery_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] cfg_hold = 16'd3;
    logic [CNT_W-1:0] cfg_to   = 16'd5;
    logic stuck_scl = 1'b0;
    logic stuck_sda = 1'b0;
    logic pad_sel, scl_lo, sda_lo, en, srst, done, err;
    wire  scl_pad = !(scl_lo | stuck_scl);
    wire  sda_pad = !(sda_lo | stuck_sda);

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    always #2 clk = ~clk;

    i2c_line_recovery #(.CNT_W(CNT_W)) u_i2c_line_recovery (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cfg_hold_i(cfg_hold), .cfg_timeout_i(cfg_to),
        .scl_pad_i(scl_pad), .sda_pad_i(sda_pad),
        .pad_gpio_sel_o(pad_sel), .scl_pull_low_o(scl_lo), .sda_pull_low_o(sda_lo),
        .ctrl_enable_o(en), .ctrl_soft_rst_o(srst), .done_o(done), .error_o(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Behavioural reference: phase number along the recovery walk.
    int  m_ph = 0;
    int  m_hold = 0;
    int  m_wait = 0;
    bit  s1_scl = 1, s2_scl = 1, s1_sda = 1, s2_sda = 1;

    function automatic bit m_sel(int p);     return p >= 2 && p <= 6; endfunction
    function automatic bit m_sdalo(int p);   return p >= 3 && p <= 5; endfunction
    function automatic bit m_scllo(int p);   return p == 4; endfunction
    function automatic bit m_en(int p);      return p == 0 || p == 10; endfunction

    always @(posedge clk) begin
        bit pscl, psda, want;
        if (!rst_n) begin
            m_ph = 0; m_hold = 0; m_wait = 0;
            s1_scl = 1; s2_scl = 1; s1_sda = 1; s2_sda = 1;
        end else begin
            pscl = !(m_scllo(m_ph) || stuck_scl);
            psda = !(m_sdalo(m_ph) || stuck_sda);
            case (m_ph)
                2: want = s2_scl && s2_sda;
                3: want = !s2_sda;
                4: want = !s2_scl;
                5: want = s2_scl;
                6: want = s2_sda;
                default: want = 0;
            endcase
            if (m_ph == 0 || m_ph == 11) begin
                if (start) begin m_ph = 1; m_hold = 0; m_wait = 0; end
            end else if (m_ph >= 2 && m_ph <= 6) begin
                if (m_hold < int'(cfg_hold)) m_hold++;
                else if (want) begin m_ph++; m_hold = 0; m_wait = 0; end
                else if (m_wait >= int'(cfg_to)) begin m_ph = 11; m_hold = 0; m_wait = 0; end
                else m_wait++;
            end else if (m_ph == 10) begin
                m_ph = 0;
            end else begin
                m_ph++;
            end
            s2_scl = s1_scl; s1_scl = pscl;
            s2_sda = s1_sda; s1_sda = psda;
        end
        #1;
        cyc++;
        chk(pad_sel == m_sel(m_ph), "R3 pad select", pad_sel, m_sel(m_ph));
        chk(sda_lo == m_sdalo(m_ph), "R3 R10 sda pull", sda_lo, m_sdalo(m_ph));
        chk(scl_lo == m_scllo(m_ph), "R3 R10 scl pull", scl_lo, m_scllo(m_ph));
        chk(en == m_en(m_ph), "R2 enable", en, m_en(m_ph));
        chk(srst == (m_ph == 8), "R7 soft reset", srst, m_ph == 8);
        chk(done == (m_ph == 10), "R8 done", done, m_ph == 10);
        chk(err == (m_ph == 11), "R6 error", err, m_ph == 11);
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    task automatic run(input int hold, input int to, input int extra_at,
                       output int seg, output int ndone, output int last_pad,
                       output int srst_at, output int done_at, output int npad,
                       output int total, output int overlap);
        bit seen_scl;
        seen_scl = 0; seg = 0; ndone = 0; last_pad = -1; srst_at = -1;
        done_at = -1; npad = 0; total = 0; overlap = 0;
        cfg_hold = CNT_W'(hold);
        cfg_to   = CNT_W'(to);
        @(negedge clk) start = 1;
        @(posedge clk); #1;
        chk(en == 0 && pad_sel == 0, "R2 disable before pads", {en, pad_sel}, 0);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk) start = (i == extra_at);
            @(posedge clk); #1;
            if (pad_sel && sda_lo && !scl_lo && !seen_scl) seg++;
            if (scl_lo) seen_scl = 1;
            if (pad_sel) begin last_pad = i; npad++; end
            if (srst) srst_at = i;
            if (srst && en) overlap++;
            if (done) begin ndone++; done_at = i; end
            total = i;
            if (done || err) break;
        end
        @(negedge clk) start = 0;
    endtask

    initial begin
        int seg, nd, lp, sa, da, np, tot, ov, tot_ref;
        repeat (3) @(negedge clk);
        #1;
        chk(en == 1 && pad_sel == 0 && !scl_lo && !sda_lo && !done && !err && !srst,
            "R1 reset state", {en, pad_sel, scl_lo, sda_lo, done, err, srst}, 7'b1000000);
        @(negedge clk) rst_n = 1;
        repeat (2) @(negedge clk);
        chk(en == 1 && pad_sel == 0, "R1 idle after reset", {en, pad_sel}, 2'b10);

        // Normal run, hold 3.
        run(3, 5, -1, seg, nd, lp, sa, da, np, tot, ov);
        tot_ref = tot;
        chk(nd == 1, "R8 one done pulse", nd, 1);
        chk(seg == 4, "R4 sda-low step length hold 3", seg, 4);
        chk(sa == lp + 2, "R7 soft reset position", sa, lp + 2);
        chk(da == lp + 4, "R7 enable return position", da, lp + 4);
        chk(ov == 0, "R11 reset while enabled", ov, 0);
        repeat (3) @(negedge clk);

        // Long hold.
        run(6, 5, -1, seg, nd, lp, sa, da, np, tot, ov);
        chk(seg == 7, "R4 sda-low step length hold 6", seg, 7);
        chk(nd == 1, "R8 done hold 6", nd, 1);

        // Zero hold exposes synchronizer latency.
        run(0, 5, -1, seg, nd, lp, sa, da, np, tot, ov);
        chk(seg == 3, "R5 two-edge synchronizer latency", seg, 3);

        // Start in mid-sequence is ignored.
        run(3, 5, 8, seg, nd, lp, sa, da, np, tot, ov);
        chk(nd == 1, "R9 extra start single done", nd, 1);
        chk(tot == tot_ref, "R9 extra start length", tot, tot_ref);
        repeat (3) @(negedge clk);
        chk(en == 1 && pad_sel == 0, "R9 idle after ignored start", {en, pad_sel}, 2'b10);

        // SDA held low externally: timeout.
        stuck_sda = 1;
        repeat (4) @(negedge clk);
        run(3, 4, -1, seg, nd, lp, sa, da, np, tot, ov);
        chk(np == 8, "R6 release-both window length", np, 8);
        chk(err == 1 && en == 0 && pad_sel == 0 && !scl_lo && !sda_lo,
            "R6 fault outputs", {err, en, pad_sel, scl_lo, sda_lo}, 5'b10000);
        chk(nd == 0, "R8 no done on fault", nd, 0);
        repeat (5) @(negedge clk);
        chk(err == 1, "R6 error held", err, 1);

        // Recover from fault once the line is free.
        stuck_sda = 0;
        repeat (4) @(negedge clk);
        run(2, 3, -1, seg, nd, lp, sa, da, np, tot, ov);
        chk(nd == 1 && err == 0, "R6 retry from fault", {nd[0], err}, 2'b10);

        // SCL held low externally.
        stuck_scl = 1;
        repeat (4) @(negedge clk);
        run(1, 2, -1, seg, nd, lp, sa, da, np, tot, ov);
        chk(np == 4 && err == 1, "R6 scl stuck timeout", np, 4);
        stuck_scl = 0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule